// File: doc/BRIEF.md
# Keyboard Scan Code to ASCII Translator

This block sits behind a keyboard receiver and turns its stream of 8-bit scan codes into ASCII letters. Each code arrives with a one-cycle valid strobe. The top bit of a code tells a key release (set) from a key press (clear). The low seven bits identify the key, so a key's release code is its press code plus 128.

Two shift keys are tracked, one on each side of the keyboard. A shift flag is set by that key's press code and cleared by its release code. A letter press produces one registered output byte, one clock after its code. The byte is upper case if either shift key is held at that moment and lower case otherwise. Releases, shift presses and key codes the block does not know produce no output. A consumer only needs to watch the valid strobe and latch the byte.

Top module: `scan_ascii_xlat`

## Requirements
- R1: After reset (active-low `rst_n`), `asciiValid` is 0, `asciiOut` is 0x00 and neither shift key counts as held. This holds even if a shift key was held when reset was asserted, so the next letter press is lower case.
- R2: A letter press code with no shift held gives `asciiValid` high for exactly the one cycle after the input strobe, with the lower-case ASCII letter on `asciiOut` (for example 0x1E gives 0x61).
- R3: While the left shift key is held (press 0x2A seen, release 0xAA not yet seen), a letter press gives the upper-case letter. The sequence 0x2A, 0x1E, 0x9E, 0xAA yields exactly one byte, 0x41, in the cycle after the 0x1E strobe.
- R4: While the right shift key is held (press 0x36, release 0xB6), a letter press gives the upper-case letter.
- R5: Shift is in effect while at least one shift key is held. Releasing one shift key while the other stays down keeps upper case. Releasing the last one returns to lower case.
- R6: A code with bit 7 set (a release) never produces an output strobe.
- R7: A press code that is not a letter key never produces an output strobe. This includes the shift keys themselves and codes such as 0x3B.
- R8: While `codeValid` is low, `codeIn` is ignored: there is no output strobe and the shift state does not change.
- R9: Letter keys are mapped by keyboard row. Codes 0x10 to 0x19 are q w e r t y u i o p, 0x1E to 0x26 are a s d f g h j k l, and 0x2C to 0x32 are z x c v b n m, each in that order.
- R10: Between output strobes, `asciiOut` keeps the last byte emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| codeValid | input | 1 | One-cycle strobe qualifying `codeIn` |
| codeIn | input | CODE_W (8) | Scan code; the top bit marks a release |
| asciiValid | output | 1 | One-cycle strobe for a translated letter |
| asciiOut | output | CODE_W (8) | ASCII letter, held between strobes |

## Verification
The bench builds the block with its default parameters: an 8-bit code and the two shift codes 0x2A and 0x36. With these, every letter on the three letter rows is reachable in both cases, as are both shift keys and their overlapping holds. A stepped vector table covers interleaved shift and letter sequences, including the one-byte capital A sequence. Directed passes then sweep all 26 letter codes with and without shift, check that codes on an idle strobe are ignored, and check that a reset taken with shift held returns the block to lower case.

// File: rtl/scan_xlat_pkg.sv
package scan_xlat_pkg;

  // Strobes passed from the shift control to the translation datapath.
  typedef struct packed {
    logic emit;   // a press code was presented this cycle
    logic upper;  // at least one shift key is currently held
  } xlatStrobe_t;

  localparam int CASE_BIT = 5;  // ASCII lower/upper differ in this bit

endpackage

// File: rtl/scan_shift_ctrl.sv
module scan_shift_ctrl
  import scan_xlat_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-2:0] LEFT_SHIFT = 7'h2A,
  parameter logic [CODE_W-2:0] RIGHT_SHIFT = 7'h36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] codeIn,
  output xlatStrobe_t       strobe
);

  localparam int KEY_W = CODE_W - 1;
  localparam int NUM_SHIFT = 2;
  localparam logic [KEY_W-1:0] SHIFT_KEYS [NUM_SHIFT] = '{LEFT_SHIFT, RIGHT_SHIFT};

  logic             isRelease;
  logic [KEY_W-1:0] keyId;
  logic [NUM_SHIFT-1:0] held;

  assign isRelease = codeIn[CODE_W-1];
  assign keyId     = codeIn[KEY_W-1:0];

  // One held flag per shift key: press sets, release clears.
  for (genvar s = 0; s < NUM_SHIFT; s++) begin : g_shift
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held[s] <= 1'b0;
      end else if (codeValid && keyId == SHIFT_KEYS[s]) begin
        held[s] <= !isRelease;
      end
    end
  end

  always_comb begin
    strobe.emit  = codeValid && !isRelease;
    strobe.upper = |held;
  end

endmodule

// File: rtl/scan_letter_dp.sv
module scan_letter_dp
  import scan_xlat_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] codeIn,
  input  xlatStrobe_t       strobe,
  output logic              asciiValid,
  output logic [CODE_W-1:0] asciiOut
);

  localparam int KEY_W = CODE_W - 1;

  logic [KEY_W-1:0]  keyId;
  logic              isLetter;
  logic [CODE_W-1:0] lowerChar;
  logic [CODE_W-1:0] caseMask;

  assign keyId = codeIn[KEY_W-1:0];

  // Key position to lower-case letter, row by row.
  always_comb begin
    isLetter  = 1'b1;
    lowerChar = '0;
    case (keyId)
      7'h10: lowerChar = "q";
      7'h11: lowerChar = "w";
      7'h12: lowerChar = "e";
      7'h13: lowerChar = "r";
      7'h14: lowerChar = "t";
      7'h15: lowerChar = "y";
      7'h16: lowerChar = "u";
      7'h17: lowerChar = "i";
      7'h18: lowerChar = "o";
      7'h19: lowerChar = "p";
      7'h1E: lowerChar = "a";
      7'h1F: lowerChar = "s";
      7'h20: lowerChar = "d";
      7'h21: lowerChar = "f";
      7'h22: lowerChar = "g";
      7'h23: lowerChar = "h";
      7'h24: lowerChar = "j";
      7'h25: lowerChar = "k";
      7'h26: lowerChar = "l";
      7'h2C: lowerChar = "z";
      7'h2D: lowerChar = "x";
      7'h2E: lowerChar = "c";
      7'h2F: lowerChar = "v";
      7'h30: lowerChar = "b";
      7'h31: lowerChar = "n";
      7'h32: lowerChar = "m";
      default: isLetter = 1'b0;
    endcase
  end

  always_comb begin
    caseMask = '0;
    caseMask[CASE_BIT] = strobe.upper;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asciiValid <= 1'b0;
      asciiOut   <= '0;
    end else begin
      asciiValid <= strobe.emit && isLetter;
      if (strobe.emit && isLetter) begin
        asciiOut <= lowerChar & ~caseMask;
      end
    end
  end

endmodule

// File: rtl/scan_ascii_xlat.sv
module scan_ascii_xlat
  import scan_xlat_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-2:0] LEFT_SHIFT = 7'h2A,
  parameter logic [CODE_W-2:0] RIGHT_SHIFT = 7'h36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] codeIn,
  output logic              asciiValid,
  output logic [CODE_W-1:0] asciiOut
);

  xlatStrobe_t strobe;

  scan_shift_ctrl #(
    .CODE_W(CODE_W), .LEFT_SHIFT(LEFT_SHIFT), .RIGHT_SHIFT(RIGHT_SHIFT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .codeValid(codeValid), .codeIn(codeIn),
    .strobe(strobe)
  );

  scan_letter_dp #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .codeIn(codeIn), .strobe(strobe),
    .asciiValid(asciiValid), .asciiOut(asciiOut)
  );

endmodule

// File: rtl/scan_ascii_xlat_checker.sv
module scan_ascii_xlat_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              codeValid,
  input logic [CODE_W-1:0] codeIn,
  input logic              asciiValid,
  input logic [CODE_W-1:0] asciiOut
);

  // R2: an output strobe only follows an input strobe
  p_out_follows_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    asciiValid |-> $past(codeValid));

  // R6: release codes never lead to an output strobe
  p_release_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (codeValid && codeIn[CODE_W-1]) |=> !asciiValid);

  // R8: an idle input cycle gives no output strobe
  p_idle_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !codeValid |=> !asciiValid);

  // R10: output byte held while no strobe
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !asciiValid |-> asciiOut == $past(asciiOut));

  // R9: every emitted byte is an ASCII letter of either case
  p_letter_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    asciiValid |-> (asciiOut[CODE_W-1:5] == 3'b010 || asciiOut[CODE_W-1:5] == 3'b011));

endmodule

bind scan_ascii_xlat scan_ascii_xlat_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .codeValid(codeValid), .codeIn(codeIn),
  .asciiValid(asciiValid), .asciiOut(asciiOut)
);

// File: tb/scan_ascii_xlat_bench.sv
module scan_ascii_xlat_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       codeValid = 1'b0;
  logic [7:0] codeIn = 8'h00;
  logic       asciiValid;
  logic [7:0] asciiOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] lastAscii = 8'h00;

  always #10 clk = ~clk;

  scan_ascii_xlat u_scan_ascii_xlat (
    .clk(clk), .rst_n(rst_n), .codeValid(codeValid), .codeIn(codeIn),
    .asciiValid(asciiValid), .asciiOut(asciiOut)
  );

  // {code, expected valid, expected byte}
  localparam int NVEC = 15;
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h1E, 1'b1, 8'h61},  // R2 plain a
    {8'h9E, 1'b0, 8'h00},  // R6
    {8'h2A, 1'b0, 8'h00},  // R7 shift press silent
    {8'h1E, 1'b1, 8'h41},  // R3 capital A
    {8'h9E, 1'b0, 8'h00},
    {8'hAA, 1'b0, 8'h00},
    {8'h1E, 1'b1, 8'h61},  // R5 back to lower
    {8'h36, 1'b0, 8'h00},
    {8'h10, 1'b1, 8'h51},  // R4 Q
    {8'h2A, 1'b0, 8'h00},
    {8'hB6, 1'b0, 8'h00},  // right released, left still held
    {8'h32, 1'b1, 8'h4D},  // R5 M
    {8'hAA, 1'b0, 8'h00},
    {8'h3B, 1'b0, 8'h00},  // R7 unmapped
    {8'h2C, 1'b1, 8'h7A}   // z
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one code for one cycle, then sample the registered result.
  task automatic step(input logic [7:0] code, input logic vld, input logic expV,
                      input logic [7:0] expA, input string req);
    codeIn = code;
    codeValid = vld;
    @(negedge clk);
    codeValid = 1'b0;
    check(asciiValid == expV, req, {15'd0, asciiValid}, {15'd0, expV});
    if (expV) begin
      check(asciiOut == expA, req, {8'd0, asciiOut}, {8'd0, expA});
      lastAscii = expA;
    end else begin
      check(asciiOut == lastAscii, "R10", {8'd0, asciiOut}, {8'd0, lastAscii});
    end
    @(negedge clk);
    check(asciiValid == 1'b0, "R2 pulse width", {15'd0, asciiValid}, 16'd0);
  endtask

  initial begin
    string rows [3] = '{"qwertyuiop", "asdfghjkl", "zxcvbnm"};
    logic [7:0] bases [3] = '{8'h10, 8'h1E, 8'h2C};

    repeat (3) @(negedge clk);
    check(asciiValid == 1'b0 && asciiOut == 8'h00, "R1",
          {7'd0, asciiValid, asciiOut}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][16:9], 1'b1, VEC[i][8], VEC[i][7:0], "R2-R7 vector");
    end

    // R8: shift code on an idle strobe does not take effect
    step(8'h2A, 1'b0, 1'b0, 8'h00, "R8");
    step(8'h1F, 1'b1, 1'b1, 8'h73, "R8 shift unchanged");

    // R9: all letters, lower then upper
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < rows[r].len(); k++) begin
        step(bases[r] + 8'(k), 1'b1, 1'b1, rows[r][k], "R9 lower");
      end
    end
    step(8'h36, 1'b1, 1'b0, 8'h00, "R4");
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < rows[r].len(); k++) begin
        step(bases[r] + 8'(k), 1'b1, 1'b1, rows[r][k] - 8'h20, "R9 upper");
      end
    end

    // R1: reset with shift held clears shift
    step(8'h2A, 1'b1, 1'b0, 8'h00, "R3");
    rst_n = 1'b0;
    @(negedge clk);
    check(asciiValid == 1'b0 && asciiOut == 8'h00, "R1 mid-run",
          {7'd0, asciiValid, asciiOut}, 16'd0);
    rst_n = 1'b1;
    lastAscii = 8'h00;
    @(negedge clk);
    step(8'h1E, 1'b1, 1'b1, 8'h61, "R1 shift cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule